// File: doc/BRIEF.md
# Prescaled 16x Baud Tick Generator

This block turns one free-running oscillator clock into the 16x baud enable used by a serial transmitter and receiver. The oscillator first passes through a prescaler whose ratio is chosen from a small set. The prescaler feeds a programmable divider whose divisor comes from a fixed 24-entry rate table. Three ratios times 24 divisors give 72 rates. Standard serial rates can therefore be reached from several common crystal frequencies by choosing the matching prescaler ratio.

A single byte written over a microprocessor bus sets the prescaler code, the rate index and the source of a general-purpose clock output. The 16x output is a pulse one oscillator cycle wide in the oscillator domain, not a derived clock. After reset the block stays idle until its first configuration write. A change of setting is picked up only when the current baud-tick period ends, so no shortened period ever appears. There is no streaming data path: the bus write and both outputs are plain control pins, and the block exerts no back-pressure because every write is accepted in the cycle it is presented.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high and after reset until the first write, `baud_x16` stays 0 and `clk_out` follows `clk_in`.
- R2: The configuration byte is laid out as bits [1:0] prescaler code, bits [6:2] rate index, bit 7 clock-output select. The gap between two consecutive `baud_x16` pulses is ratio × divisor oscillator cycles. For indices 0 to 23 the divisors are 768, 512, 349, 286, 256, 192, 128, 96, 64, 48, 32, 24, 21, 19, 16, 12, 11, 8, 6, 5, 4, 3, 2, 1.
- R3: Prescaler code 0 divides by 3, code 1 divides by 4, and codes 2 and 3 both divide by 5.
- R4: Rate indices 24 to 31 select divisor 768.
- R5: Each `baud_x16` pulse is high for exactly one `clk_in` cycle.
- R6: A write during a period leaves that period's length unchanged. The new ratio and divisor apply from the pulse that ends it.
- R7: With bit 7 set, `clk_out` equals `baud_x16`. With bit 7 clear, `clk_out` equals `clk_in`.
- R8: After the first write following reset, the first `baud_x16` pulse is high in the second clock cycle after the edge that captured the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Oscillator clock; all state is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the idle state |
| bus_wr | input | 1 | Write strobe for the configuration byte |
| bus_wdata | input | 8 | Configuration byte: [1:0] prescaler code, [6:2] rate index, [7] clock-output select |
| baud_x16 | output | 1 | One-cycle enable pulse at 16 times the baud rate |
| clk_out | output | 1 | General-purpose clock: oscillator or 16x pulse, by bit 7 |

## Verification
The hardest case to reach is a write that lands in the middle of a long period. If the design picked up the new prescaler ratio on the prescaler's own wrap rather than on the divider's wrap, the period in progress would come out with a mixed length. The stimulus chains all 72 ratio-and-index settings back to back. Each write is issued right after a pulse, so every measured interval straddles a setting change. One extra case waits 500 cycles into a 2304-cycle period before switching to the fastest rate. Intervals are measured purely from pulse spacing at the output.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int IDX_W   = 5;
  localparam int DIV_W   = 10;
  localparam int PRE_W   = 3;
  localparam int PRE_MAX = 5;
  localparam int N_RATES = 24;

  function automatic logic [PRE_W-1:0] pre_ratio(input logic [1:0] code);
    case (code)
      2'd0:    pre_ratio = PRE_W'(3);
      2'd1:    pre_ratio = PRE_W'(4);
      default: pre_ratio = PRE_W'(5);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] rate_div(input logic [IDX_W-1:0] idx);
    case (idx)
      5'd0:  rate_div = DIV_W'(768);
      5'd1:  rate_div = DIV_W'(512);
      5'd2:  rate_div = DIV_W'(349);
      5'd3:  rate_div = DIV_W'(286);
      5'd4:  rate_div = DIV_W'(256);
      5'd5:  rate_div = DIV_W'(192);
      5'd6:  rate_div = DIV_W'(128);
      5'd7:  rate_div = DIV_W'(96);
      5'd8:  rate_div = DIV_W'(64);
      5'd9:  rate_div = DIV_W'(48);
      5'd10: rate_div = DIV_W'(32);
      5'd11: rate_div = DIV_W'(24);
      5'd12: rate_div = DIV_W'(21);
      5'd13: rate_div = DIV_W'(19);
      5'd14: rate_div = DIV_W'(16);
      5'd15: rate_div = DIV_W'(12);
      5'd16: rate_div = DIV_W'(11);
      5'd17: rate_div = DIV_W'(8);
      5'd18: rate_div = DIV_W'(6);
      5'd19: rate_div = DIV_W'(5);
      5'd20: rate_div = DIV_W'(4);
      5'd21: rate_div = DIV_W'(3);
      5'd22: rate_div = DIV_W'(2);
      5'd23: rate_div = DIV_W'(1);
      default: rate_div = DIV_W'(768);
    endcase
  endfunction
endpackage

// File: rtl/brg_cfg_reg.sv
module brg_cfg_reg
  import brg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [7:0]       wdata,
  output logic             armed,
  output logic [1:0]       pre_code,
  output logic [IDX_W-1:0] rate_idx,
  output logic             co_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      pre_code <= 2'd0;
      rate_idx <= '0;
      co_sel   <= 1'b0;
    end else if (wr) begin
      armed    <= 1'b1;
      pre_code <= wdata[1:0];
      rate_idx <= wdata[2 +: IDX_W];
      co_sel   <= wdata[7];
    end
  end
endmodule

// File: rtl/brg_prescaler.sv
module brg_prescaler
  import brg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] ratio,
  output logic             pre_tick
);
  logic [PRE_W-1:0] cnt;

  assign pre_tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (pre_tick) cnt <= ratio - PRE_W'(1);
    else               cnt <= cnt - PRE_W'(1);
  end

  // R3
  pre_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < PRE_W'(PRE_MAX)));
endmodule

// File: rtl/brg_divider.sv
module brg_divider
  import brg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_tick,
  input  logic [DIV_W-1:0] reload,
  output logic             term
);
  logic [DIV_W-1:0] cnt;

  assign term = pre_tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (term)     cnt <= reload - DIV_W'(1);
    else if (pre_tick) cnt <= cnt - DIV_W'(1);
  end

  // R6
  div_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && pre_tick && cnt != '0) |=> (cnt == $past(cnt) - DIV_W'(1)));

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !pre_tick) |=> $stable(cnt));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import brg_pkg::*;
(
  input  logic       clk_in,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic       baud_x16,
  output logic       clk_out
);
  logic             armed, co_sel, pre_tick, term, take;
  logic [1:0]       pre_code;
  logic [IDX_W-1:0] rate_idx;
  logic [PRE_W-1:0] act_ratio, nxt_ratio;
  logic [DIV_W-1:0] act_div, nxt_div;
  logic             tick_q;

  brg_cfg_reg u_cfg (
    .clk(clk_in), .rst(rst), .wr(bus_wr), .wdata(bus_wdata),
    .armed(armed), .pre_code(pre_code), .rate_idx(rate_idx), .co_sel(co_sel)
  );

  // settings move to the active copy only at a period boundary
  assign take      = !armed || term;
  assign nxt_ratio = take ? pre_ratio(pre_code) : act_ratio;
  assign nxt_div   = take ? rate_div(rate_idx)  : act_div;

  always_ff @(posedge clk_in) begin
    if (rst) begin
      act_ratio <= PRE_W'(3);
      act_div   <= DIV_W'(768);
      tick_q    <= 1'b0;
    end else begin
      act_ratio <= nxt_ratio;
      act_div   <= nxt_div;
      tick_q    <= term;
    end
  end

  brg_prescaler u_pre (
    .clk(clk_in), .rst(rst), .run(armed), .ratio(nxt_ratio), .pre_tick(pre_tick)
  );

  brg_divider u_div (
    .clk(clk_in), .rst(rst), .run(armed), .pre_tick(pre_tick),
    .reload(nxt_div), .term(term)
  );

  assign baud_x16 = tick_q;
  assign clk_out  = co_sel ? tick_q : clk_in;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_in) disable iff (rst)
    !armed |=> !baud_x16);

  // R5
  tick_width_chk: assert property (@(posedge clk_in) disable iff (rst)
    baud_x16 |=> !baud_x16);

  // R6
  act_hold_chk: assert property (@(posedge clk_in) disable iff (rst)
    (armed && !term) |=> ($stable(act_ratio) && $stable(act_div)));
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, wr;
  logic [7:0] wd;
  logic       tick, co;
  int n_run = 0, n_fail = 0;
  int    exp_q[$];
  string tag_q[$];

  baud_tick_gen u_dut (
    .clk_in(clk), .rst(rst), .bus_wr(wr), .bus_wdata(wd),
    .baud_x16(tick), .clk_out(co)
  );

  function automatic int ratio_of(int c);
    return (c == 0) ? 3 : (c == 1) ? 4 : 5;
  endfunction

  function automatic int div_of(int i);
    case (i)
      0: return 768;  1: return 512;  2: return 349;  3: return 286;
      4: return 256;  5: return 192;  6: return 128;  7: return 96;
      8: return 64;   9: return 48;  10: return 32;  11: return 24;
      12: return 21; 13: return 19;  14: return 16;  15: return 12;
      16: return 11; 17: return 8;   18: return 6;   19: return 5;
      20: return 4;  21: return 3;   22: return 2;   23: return 1;
      default: return 768;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input int code, input int idx, input bit cs);
    @(negedge clk);
    wr = 1'b1;
    wd = {cs, 5'(idx), 2'(code)};
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic push(input int p, input string tag);
    exp_q.push_back(p);
    tag_q.push_back(tag);
  endtask

  // monitor: measures pulse spacing and scores it against the queue
  initial begin
    int cnt = 0;
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst) begin
        cnt = 0; prev = 1'b0;
      end else begin
        cnt++;
        if (tick) begin
          chk(!prev, "R5 pulse width", int'(prev), 0);
          if (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(cnt == e, t, cnt, e);
          end
          cnt = 0;
        end
        prev = tick;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int codes[$];
    int idxs[$];
    string tags[$];
    int ticks;
    rst = 1'b1; wr = 1'b0; wd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tick == 1'b0, "R1 in reset", tick, 0);
    rst = 1'b0;

    // R1: idle until programmed, clk_out carries the oscillator
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(tick == 1'b0, "R1 idle tick", tick, 0);
      chk(co == 1'b0, "R1 clk_out low phase", co, 0);
      @(posedge clk); #2;
      chk(co == 1'b1, "R1 clk_out high phase", co, 1);
    end

    // R8: first pulse timing after the first write
    write_cfg(0, 0, 1'b0);
    chk(tick == 1'b0, "R8 before first pulse", tick, 0);
    @(negedge clk);
    chk(tick == 1'b1, "R8 first pulse", tick, 1);
    @(posedge clk);
    push(3 * 768, "R2 code0 idx0");

    // all 72 settings, then R3 code 3 and R4 out-of-table indices
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 24; i++) begin
        if (c == 0 && i == 0) continue;
        codes.push_back(c); idxs.push_back(i); tags.push_back("R2 rate table");
      end
    codes.push_back(3); idxs.push_back(0);  tags.push_back("R3 code3 idx0");
    codes.push_back(3); idxs.push_back(23); tags.push_back("R3 code3 idx23");
    codes.push_back(1); idxs.push_back(17); tags.push_back("R3 code1 idx17");
    codes.push_back(0); idxs.push_back(24); tags.push_back("R4 idx24");
    codes.push_back(0); idxs.push_back(31); tags.push_back("R4 idx31");
    codes.push_back(2); idxs.push_back(27); tags.push_back("R4 idx27");

    // each write lands mid-period, so every old interval also checks R6
    for (int k = 0; k < codes.size(); k++) begin
      write_cfg(codes[k], idxs[k], 1'b0);
      wait_tick();
      @(posedge clk);
      push(ratio_of(codes[k]) * div_of(idxs[k]), tags[k]);
    end

    // R6: late write deep inside a long period
    write_cfg(0, 0, 1'b0);
    wait_tick();
    @(posedge clk);
    push(2304, "R6 period kept");
    repeat (500) @(posedge clk);
    write_cfg(0, 23, 1'b0);
    wait_tick();
    @(posedge clk);
    push(3, "R6 new period");
    wait_tick();
    @(posedge clk);
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

    // R7: clk_out carries the pulse stream
    write_cfg(0, 23, 1'b1);
    wait_tick();
    wait_tick();
    ticks = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(co == tick, "R7 clk_out low phase", co, tick);
      if (tick) ticks++;
      @(posedge clk); #2;
      chk(co == tick, "R7 clk_out high phase", co, tick);
    end
    chk(ticks == 4, "R7 pulse count", ticks, 4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule